// File: doc/BRIEF.md
# Interrupt Controller Register Block

This block is the software-visible register file of a per-core interrupt controller. A simple synchronous port carries an address, 32-bit write data, a write strobe and a read strobe. Every register applies its own write rule. Some registers keep only a byte. One keeps only its top byte. One has its low bits held at one. One cannot be written at all. Six interrupt-source entries protect two status bits. The error status register needs two writes before it clears.

The block also drives two status outputs. `sw_enable` carries the enable bit taken from the last write to the spurious-vector register. `err_armed` shows the state of the error-status write sequence. Any access to an address outside the implemented set is answered with an error response and leaves all state as it was.

Top module: `icr_regbank`

## Requirements
- R1: After reset, every register reads 0, except the destination-format register (address 4), which reads 0xFFFFFFFF. `sw_enable`, `err_armed`, `rd_valid` and `resp_err` are all 0.
- R2: A write to the identity register (address 0) or to the task-priority register (address 2) stores only bits 7:0. Bits 31:8 read back as 0.
- R3: A write to the logical-destination register (address 3) stores only bits 31:24. Bits 23:0 read back as 0.
- R4: A write to the destination-format register (address 4) stores bits 31:28 from the write data. Bits 27:0 always read back as 1.
- R5: The version register (address 1) always reads the parameter `VERSION_VAL`, which defaults to 0. A write to it changes nothing.
- R6: There are `NUM_LVT` interrupt-source entries, at addresses 8 upward in the order timer, thermal, performance counter, local pin 0, local pin 1, error. On a write, bits 12 and 14 of an entry keep their previous value. All other bits take the write data.
- R7: A write to the error-status register (address 6) while `err_armed` is 0 sets `err_armed` to 1 and leaves the register value unchanged.
- R8: A write to the error-status register while `err_armed` is 1 clears `err_armed` and sets the register to 0.
- R9: A read of the error-status register clears `err_armed`.
- R10: A write to the spurious-vector register (address 5) stores all 32 bits. Bit 8 of the write data becomes the value of `sw_enable`.
- R11: A read of an implemented address with `wr_en` low raises `rd_valid` on the next cycle, with the stored value on `rd_data`. `rd_data` is 0 whenever `rd_valid` is low.
- R12: An access to an unimplemented address (7, and every address from 8+`NUM_LVT` upward) raises `resp_err` for one cycle on the next cycle. It does not raise `rd_valid` and changes no register or status output.
- R13: When `wr_en` and `rd_en` are both high in the same cycle, the write is performed, the read is ignored and `rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response, one cycle after rd_en |
| resp_err | output | 1 | Error response for an unimplemented address |
| sw_enable | output | 1 | Software-enable bit from the spurious-vector register |
| err_armed | output | 1 | Error-status write sequence is armed |

## Verification
The bench builds the block with its default parameters: `ADDR_W` = 5, `NUM_LVT` = 6 and `VERSION_VAL` = 0. With a 5-bit address, both the gap at address 7 and the addresses from 14 to 31 above the six entries can be reached, so the unimplemented-address response is exercised on both sides of the entry range. All six entries are reached with all-ones and with mixed patterns. With these values the error-status arm sequence can be driven through write–write, write–read and read-only orders.

// File: rtl/icr_pkg.sv
package icr_pkg;

    localparam int DW         = 32;
    localparam int LVT_IDX_W  = 4;

    localparam int A_IDENT    = 0;
    localparam int A_VERSION  = 1;
    localparam int A_TPRI     = 2;
    localparam int A_LDST     = 3;
    localparam int A_DFMT     = 4;
    localparam int A_SPUR     = 5;
    localparam int A_ERRST    = 6;
    localparam int A_LVT_BASE = 8;

    localparam logic [DW-1:0] LVT_RO_MASK = 32'h0000_5000;
    localparam logic [DW-1:0] DFMT_FORCE  = 32'h0FFF_FFFF;
    localparam logic [DW-1:0] LDST_KEEP   = 32'hFF00_0000;
    localparam logic [DW-1:0] DFMT_RESET  = 32'hFFFF_FFFF;
    localparam int            SWEN_BIT    = 8;

    typedef enum logic [3:0] {
        K_IDENT, K_VERSION, K_TPRI, K_LDST, K_DFMT,
        K_SPUR, K_ERRST, K_LVT, K_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e              kind;
        logic [LVT_IDX_W-1:0]   lvt_idx;
    } reg_sel_t;

    function automatic logic [DW-1:0] keep_low_byte(input logic [DW-1:0] d);
        return {{(DW-8){1'b0}}, d[7:0]};
    endfunction

    function automatic logic [DW-1:0] lvt_merge(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] new_v);
        return (new_v & ~LVT_RO_MASK) | (old_v & LVT_RO_MASK);
    endfunction

endpackage

// File: rtl/icr_decode.sv
module icr_decode
    import icr_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int NUM_LVT = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int LVT_END = A_LVT_BASE + NUM_LVT;

    int a;
    always_comb begin
        a           = int'(addr);
        sel.kind    = K_NONE;
        sel.lvt_idx = '0;
        if      (a == A_IDENT)   sel.kind = K_IDENT;
        else if (a == A_VERSION) sel.kind = K_VERSION;
        else if (a == A_TPRI)    sel.kind = K_TPRI;
        else if (a == A_LDST)    sel.kind = K_LDST;
        else if (a == A_DFMT)    sel.kind = K_DFMT;
        else if (a == A_SPUR)    sel.kind = K_SPUR;
        else if (a == A_ERRST)   sel.kind = K_ERRST;
        else if (a >= A_LVT_BASE && a < LVT_END) begin
            sel.kind    = K_LVT;
            sel.lvt_idx = LVT_IDX_W'(a - A_LVT_BASE);
        end
    end
endmodule

// File: rtl/icr_lvt_bank.sv
module icr_lvt_bank
    import icr_pkg::*;
#(
    parameter int NUM_LVT = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_hit,
    input  logic [LVT_IDX_W-1:0] idx,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata
);
    logic [DW-1:0] entry_q [NUM_LVT];

    for (genvar g = 0; g < NUM_LVT; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry_q[g] <= '0;
            else if (wr_hit && int'(idx) == g)
                entry_q[g] <= lvt_merge(entry_q[g], wdata);
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_LVT; i++)
            if (int'(idx) == i) rdata = entry_q[i];
    end
endmodule

// File: rtl/icr_errst.sv
module icr_errst
    import icr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hit,
    input  logic          rd_hit,
    output logic          armed,
    output logic [DW-1:0] value
);
    logic          armed_q;
    logic [DW-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            value_q <= '0;
        end else if (wr_hit) begin
            if (armed_q) begin
                armed_q <= 1'b0;
                value_q <= '0;
            end else begin
                armed_q <= 1'b1;
            end
        end else if (rd_hit) begin
            armed_q <= 1'b0;
        end
    end

    assign armed = armed_q;
    assign value = value_q;
endmodule

// File: rtl/icr_regbank.sv
module icr_regbank
    import icr_pkg::*;
#(
    parameter int              ADDR_W      = 5,
    parameter int              NUM_LVT     = 6,
    parameter logic [31:0]     VERSION_VAL = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              resp_err,
    output logic              sw_enable,
    output logic              err_armed
);
    reg_sel_t      sel;
    logic          known;
    logic          rd_fire;
    logic [DW-1:0] ident_q, tpri_q, ldst_q, dfmt_q, spur_q;
    logic          swen_q;
    logic [DW-1:0] lvt_rd, errst_val, rd_mux;
    logic [DW-1:0] rd_data_q;
    logic          rd_valid_q, resp_err_q;

    icr_decode #(.ADDR_W(ADDR_W), .NUM_LVT(NUM_LVT)) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    assign known   = (sel.kind != K_NONE);
    assign rd_fire = rd_en && !wr_en;

    icr_lvt_bank #(.NUM_LVT(NUM_LVT)) u_lvt (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_en && sel.kind == K_LVT),
        .idx    (sel.lvt_idx),
        .wdata  (wdata),
        .rdata  (lvt_rd)
    );

    icr_errst u_errst (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_en && sel.kind == K_ERRST),
        .rd_hit (rd_fire && sel.kind == K_ERRST),
        .armed  (err_armed),
        .value  (errst_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ident_q <= '0;
            tpri_q  <= '0;
            ldst_q  <= '0;
            dfmt_q  <= DFMT_RESET;
            spur_q  <= '0;
            swen_q  <= 1'b0;
        end else if (wr_en) begin
            case (sel.kind)
                K_IDENT: ident_q <= keep_low_byte(wdata);
                K_TPRI:  tpri_q  <= keep_low_byte(wdata);
                K_LDST:  ldst_q  <= wdata & LDST_KEEP;
                K_DFMT:  dfmt_q  <= wdata | DFMT_FORCE;
                K_SPUR: begin
                    spur_q <= wdata;
                    swen_q <= wdata[SWEN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel.kind)
            K_IDENT:   rd_mux = ident_q;
            K_VERSION: rd_mux = VERSION_VAL;
            K_TPRI:    rd_mux = tpri_q;
            K_LDST:    rd_mux = ldst_q;
            K_DFMT:    rd_mux = dfmt_q;
            K_SPUR:    rd_mux = spur_q;
            K_ERRST:   rd_mux = errst_val;
            K_LVT:     rd_mux = lvt_rd;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
            resp_err_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_fire && known;
            rd_data_q  <= (rd_fire && known) ? rd_mux : '0;
            resp_err_q <= (wr_en || rd_en) && !known;
        end
    end

    assign rd_data   = rd_data_q;
    assign rd_valid  = rd_valid_q;
    assign resp_err  = resp_err_q;
    assign sw_enable = swen_q;
endmodule

// File: rtl/icr_regbank_chk.sv
module icr_regbank_chk
    import icr_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int NUM_LVT = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic              rd_valid,
    input logic              resp_err,
    input logic              sw_enable,
    input logic              err_armed
);
    logic in_map;
    logic is_lvt;
    assign is_lvt = int'(addr) >= A_LVT_BASE && int'(addr) < A_LVT_BASE + NUM_LVT;
    assign in_map = int'(addr) <= A_ERRST || is_lvt;

    a_r11_read_valid: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && in_map) |=> rd_valid);

    a_r13_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !rd_valid);

    a_r7_arm_on_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(addr) == A_ERRST && !err_armed) |=> err_armed);

    a_r8_disarm_on_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(addr) == A_ERRST && err_armed) |=> !err_armed);

    a_r9_read_disarms: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && int'(addr) == A_ERRST) |=> !err_armed);

    a_r10_swen_capture: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(addr) == A_SPUR) |=> sw_enable == $past(wdata[SWEN_BIT]));

    a_r12_err_no_effect: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_en) && !in_map) |=>
            (resp_err && !rd_valid && $stable(sw_enable) && $stable(err_armed)));

    a_r4_fmt_low_ones: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && int'(addr) == A_DFMT) |=> rd_data[27:0] == 28'hFFF_FFFF);

    a_r6_lvt_ro_bits: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && is_lvt) |=> (!rd_data[12] && !rd_data[14]));

    a_r11_idle_data_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == 32'h0);
endmodule

bind icr_regbank icr_regbank_chk #(.ADDR_W(ADDR_W), .NUM_LVT(NUM_LVT)) u_chk (.*);

// File: tb/icr_regbank_bench.sv
module icr_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic          rd_valid, resp_err, sw_enable, err_armed;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    typedef struct {
        logic        v;
        logic        e;
        logic [31:0] d;
        int          stamp;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    icr_regbank u_icr_regbank (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .resp_err(resp_err), .sw_enable(sw_enable), .err_armed(err_armed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
        end
    endtask

    // monitor: pops the item due this cycle and compares the response
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0 && exp_q[0].stamp < cyc) begin
            exp_t it;
            it = exp_q.pop_front();
            check({it.tag, " rd_valid"}, {31'b0, rd_valid}, {31'b0, it.v});
            check({it.tag, " resp_err"}, {31'b0, resp_err}, {31'b0, it.e});
            check({it.tag, " rd_data"}, rd_data, it.v ? it.d : 32'h0);
        end
    end

    task automatic drive(input logic w, input logic r, input int a, input logic [31:0] d,
                         input logic ev, input logic ee, input logic [31:0] ed, input string tag);
        exp_t it;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = AW'(a); wdata = d;
        it.v = ev; it.e = ee; it.d = ed; it.stamp = cyc; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        drive(1'b1, 1'b0, a, d, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic rd(input int a, input logic [31:0] ed, input string tag);
        drive(1'b0, 1'b1, a, 32'h0, 1'b1, 1'b0, ed, tag);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 0, 32'h0, 1'b0, 1'b0, 32'h0, "idle");
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: reset state of status outputs and registers
        check("R1 sw_enable", {31'b0, sw_enable}, 32'h0);
        check("R1 err_armed", {31'b0, err_armed}, 32'h0);
        check("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
        for (int a = 0; a <= 6; a++) rd(a, (a == 4) ? 32'hFFFF_FFFF : 32'h0, "R1 reset value");
        for (int k = 0; k < 6; k++) rd(8 + k, 32'h0, "R1 reset lvt");

        // R2 byte registers
        wr(0, 32'hABCD_1234, "R2 wr ident");
        wr(2, 32'hFFFF_FF5A, "R2 wr tpri");
        rd(0, 32'h0000_0034, "R2 ident");
        rd(2, 32'h0000_005A, "R2 tpri");

        // R3 logical destination
        wr(3, 32'h1234_5678, "R3 wr");
        rd(3, 32'h1200_0000, "R3 ldst");

        // R4 destination format
        wr(4, 32'h5000_0000, "R4 wr");
        rd(4, 32'h5FFF_FFFF, "R4 fmt");
        wr(4, 32'h0000_0000, "R4 wr zero");
        rd(4, 32'h0FFF_FFFF, "R4 fmt low ones");

        // R5 version read only
        wr(1, 32'hDEAD_BEEF, "R5 wr");
        rd(1, 32'h0, "R5 version");

        // R6 lvt entries
        for (int k = 0; k < 6; k++) wr(8 + k, 32'hFFFF_FFFF, "R6 wr ones");
        for (int k = 0; k < 6; k++) rd(8 + k, 32'hFFFF_AFFF, "R6 ro bits");
        for (int k = 0; k < 6; k++) wr(8 + k, 32'h0001_2345 + k, "R6 wr pattern");
        for (int k = 0; k < 6; k++) rd(8 + k, (32'h0001_2345 + k) & ~32'h5000, "R6 pattern");

        // R10 spurious vector
        wr(5, 32'h0000_01FF, "R10 wr");
        idle();
        check("R10 sw_enable set", {31'b0, sw_enable}, 32'h1);
        rd(5, 32'h0000_01FF, "R10 spur");
        wr(5, 32'h0000_00FF, "R10 wr clr");
        idle();
        check("R10 sw_enable clr", {31'b0, sw_enable}, 32'h0);

        // R7 / R8 / R9 error status sequence
        wr(6, 32'h55, "R7 arm");
        idle();
        check("R7 armed", {31'b0, err_armed}, 32'h1);
        rd(6, 32'h0, "R7 value unchanged");
        idle();
        check("R9 read disarms", {31'b0, err_armed}, 32'h0);
        wr(6, 32'hAA, "R7 arm again");
        wr(6, 32'hAA, "R8 clear");
        idle();
        check("R8 disarmed", {31'b0, err_armed}, 32'h0);
        rd(6, 32'h0, "R8 value zero");
        idle();
        check("R9 stays clear", {31'b0, err_armed}, 32'h0);

        // R12 unimplemented addresses; arm first so a stray change is visible
        wr(6, 32'h1, "R12 arm");
        drive(1'b1, 1'b0, 7, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0, "R12 wr gap");
        drive(1'b0, 1'b1, 14, 32'h0, 1'b0, 1'b1, 32'h0, "R12 rd high");
        drive(1'b1, 1'b0, 31, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0, "R12 wr top");
        idle();
        check("R12 armed kept", {31'b0, err_armed}, 32'h1);
        check("R12 swen kept", {31'b0, sw_enable}, 32'h0);
        rd(0, 32'h0000_0034, "R12 ident kept");
        rd(13, (32'h0001_2345 + 5) & ~32'h5000, "R12 lvt kept");

        // R13 write and read together
        drive(1'b1, 1'b1, 0, 32'h0000_0077, 1'b0, 1'b0, 32'h0, "R13 wr+rd");
        rd(0, 32'h0000_0077, "R13 write done");

        // R11 back-to-back reads
        rd(2, 32'h0000_005A, "R11 b2b a");
        rd(3, 32'h1200_0000, "R11 b2b b");
        idle();
        idle();
        idle();
        done = 1;
        summary();
        $finish;
    end
endmodule